// File: doc/BRIEF.md
# Host-to-Processor Doorbell Register

A 32-bit doorbell shared by two bus agents. The external host side can only raise bits in it, and the local processor side can only lower them, so each side signals the other without a read-modify-write race. The host rings a doorbell by writing ones. The processor acknowledges it by writing ones to the bits it has handled.

The top bit is reserved as an error doorbell. It drives its own interrupt line, which has its own mask. The remaining 31 bits are ORed into a single normal interrupt that is gated by a doorbell mask. Both interrupt outputs are registered levels.

Each side has a single-cycle access port with valid, write, address and data, and no wait states. Each port answers only at its own offset.

Top module: `host_doorbell_reg`

## Requirements
- R1: After a synchronous active-low reset, the register holds zero and both interrupt outputs are low.
- R2: A host-port write sets every bit written as 1 and leaves every bit written as 0 unchanged. The host port never clears a bit.
- R3: A processor-port write clears every bit written as 1 and leaves every bit written as 0 unchanged. The processor port never sets a bit.
- R4: When a host set and a processor clear hit the same bit in the same cycle, the bit ends up set.
- R5: The host port acts only at offset 0x0020 and the processor port only at offset 0x4020. A write at any other offset, including the other port's offset, changes nothing.
- R6: A read (valid=1, write=0, own offset) returns the register value of that cycle on the port's read-data output in the same cycle. Otherwise read data is zero. Reads change no state.
- R7: `irq_err` equals, one cycle later, bit 31 AND NOT `err_mask`. `norm_mask` has no effect on it.
- R8: `irq_norm` equals, one cycle later, (OR of bits 30:0) AND NOT `norm_mask`. `err_mask` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_valid | input | 1 | Host access strobe |
| h_write | input | 1 | Host access is a write (set) |
| h_addr | input | 16 | Host offset |
| h_wdata | input | 32 | Host set mask |
| h_rdata | output | 32 | Host read data |
| c_valid | input | 1 | Processor access strobe |
| c_write | input | 1 | Processor access is a write (clear) |
| c_addr | input | 16 | Processor offset |
| c_wdata | input | 32 | Processor clear mask |
| c_rdata | output | 32 | Processor read data |
| norm_mask | input | 1 | Masks the normal interrupt |
| err_mask | input | 1 | Masks the error interrupt |
| irq_norm | output | 1 | Normal doorbell interrupt level |
| irq_err | output | 1 | Error doorbell interrupt level |

## Verification
The bench builds the block with its defaults: 32 data bits, 16 address bits, and offsets 0x0020 and 0x4020. With these values the error bit sits at 31 and both decode offsets are exercised, including each port being driven with the other port's offset. Directed phases cover set/clear collisions and the independence of the two masks. A long random phase then mixes set, clear and read accesses at matching and stray offsets on both ports at once.

// File: rtl/doorbell_pkg.sv
// Package: shared sizes and offsets of the doorbell register.
// Assumes: both ports share one address width.
package doorbell_pkg;
    localparam int DB_DATA_W = 32;
    localparam int DB_ADDR_W = 16;
    localparam logic [DB_ADDR_W-1:0] DB_HOST_OFS = 16'h0020;
    localparam logic [DB_ADDR_W-1:0] DB_CPU_OFS  = 16'h4020;
endpackage

// File: rtl/db_port_decode.sv
// Module: decodes one single-cycle access port at a fixed offset.
// Turns a matching write into a bit mask and flags a matching read.
// Assumes: no wait states; stray offsets are simply ignored.
module db_port_decode #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] OFFSET = '0
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] wr_mask,
    output logic              rd_hit
);
    logic hit;

    // Address match for this port only.
    always_comb hit = valid && (addr == OFFSET);

    // Write mask and read strobe from the matched access.
    always_comb begin
        wr_mask = (hit && write) ? wdata : '0;
        rd_hit  = hit && !write;
    end
endmodule

// File: rtl/db_bits.sv
// Module: the doorbell storage with set-only and clear-only inputs.
// Assumes: set has priority over clear on the same bit.
module db_bits #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] bits_q
);
    // Per-bit update: clear first, then set, so a collision keeps the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= (bits_q & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/db_irq.sv
// Module: registered interrupt levels from the doorbell state.
// Top bit drives the error line; all lower bits drive the normal line.
// Assumes: each mask gates only its own line.
module db_irq #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bits_q,
    input  logic              norm_mask,
    input  logic              err_mask,
    output logic              irq_norm,
    output logic              irq_err
);
    localparam int ERR_BIT = DATA_W - 1;

    // Register both interrupt levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_norm <= 1'b0;
            irq_err  <= 1'b0;
        end else begin
            irq_norm <= (|bits_q[ERR_BIT-1:0]) && !norm_mask;
            irq_err  <= bits_q[ERR_BIT] && !err_mask;
        end
    end
endmodule

// File: rtl/host_doorbell_reg.sv
// Module: two-agent doorbell. The host sets bits, the processor clears them.
// Bit 31 raises the error interrupt; bits 30:0 raise the normal one.
// Assumes: both ports are synchronous to clk; reset is synchronous, active low.
module host_doorbell_reg
    import doorbell_pkg::*;
#(
    parameter int DATA_W = DB_DATA_W,
    parameter int ADDR_W = DB_ADDR_W,
    parameter logic [ADDR_W-1:0] HOST_OFS = DB_HOST_OFS,
    parameter logic [ADDR_W-1:0] CPU_OFS  = DB_CPU_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_valid,
    input  logic              h_write,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              c_valid,
    input  logic              c_write,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    input  logic              norm_mask,
    input  logic              err_mask,
    output logic              irq_norm,
    output logic              irq_err
);
    localparam int ERR_BIT = DATA_W - 1;

    logic [DATA_W-1:0] host_set;
    logic [DATA_W-1:0] cpu_clr;
    logic              host_rd;
    logic              cpu_rd;
    logic [DATA_W-1:0] db_q;

    db_port_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFFSET(HOST_OFS)) u_host (
        .valid(h_valid), .write(h_write), .addr(h_addr), .wdata(h_wdata),
        .wr_mask(host_set), .rd_hit(host_rd)
    );

    db_port_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFFSET(CPU_OFS)) u_cpu (
        .valid(c_valid), .write(c_write), .addr(c_addr), .wdata(c_wdata),
        .wr_mask(cpu_clr), .rd_hit(cpu_rd)
    );

    db_bits #(.DATA_W(DATA_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .set_mask(host_set), .clr_mask(cpu_clr),
        .bits_q(db_q)
    );

    db_irq #(.DATA_W(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .bits_q(db_q), .norm_mask(norm_mask),
        .err_mask(err_mask), .irq_norm(irq_norm), .irq_err(irq_err)
    );

    // Side-effect-free read return on each port.
    always_comb begin
        h_rdata = host_rd ? db_q : '0;
        c_rdata = cpu_rd  ? db_q : '0;
    end

    AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((db_q & ~$past(db_q) & ~$past(host_set)) == '0)); // R3
    AST_NO_STRAY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~db_q & $past(db_q) & ~$past(cpu_clr)) == '0)); // R2
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((db_q & $past(host_set)) == $past(host_set))); // R4
    AST_ERR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_err == ($past(db_q[ERR_BIT]) && !$past(err_mask)))); // R7
    AST_NORM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_norm == ((|$past(db_q[ERR_BIT-1:0])) && !$past(norm_mask)))); // R8
    AST_HOST_IDLE_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_valid && !h_write && h_addr == HOST_OFS) |-> (h_rdata == '0)); // R6
endmodule

// File: tb/sim_host_doorbell_reg.sv
module sim_host_doorbell_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] HOFS = 16'h0020;
    localparam logic [15:0] COFS = 16'h4020;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_valid = 0, h_write = 0, c_valid = 0, c_write = 0;
    logic [15:0] h_addr = '0, c_addr = '0;
    logic [31:0] h_wdata = '0, c_wdata = '0;
    logic [31:0] h_rdata, c_rdata;
    logic norm_mask = 0, err_mask = 0;
    logic irq_norm, irq_err;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] mq = '0;   // behavioural model of the doorbell
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_doorbell_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_valid(c_valid), .c_write(c_write), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .norm_mask(norm_mask), .err_mask(err_mask), .irq_norm(irq_norm), .irq_err(irq_err)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus, compared with the model.
    task automatic step(input logic hv, input logic hw, input logic [15:0] ha, input logic [31:0] hd,
                        input logic cv, input logic cw, input logic [15:0] ca, input logic [31:0] cd,
                        input logic nm, input logic em, input string tag);
        logic [31:0] set_m, clr_m;
        logic en, ee;
        h_valid = hv; h_write = hw; h_addr = ha; h_wdata = hd;
        c_valid = cv; c_write = cw; c_addr = ca; c_wdata = cd;
        norm_mask = nm; err_mask = em;
        #1;
        check(tag, "h_rdata", h_rdata, (hv && !hw && ha == HOFS) ? mq : 32'h0);
        check(tag, "c_rdata", c_rdata, (cv && !cw && ca == COFS) ? mq : 32'h0);
        set_m = (hv && hw && ha == HOFS) ? hd : 32'h0;
        clr_m = (cv && cw && ca == COFS) ? cd : 32'h0;
        en = (mq[30:0] != 0) && !nm;
        ee = mq[31] && !em;
        mq = (mq & ~clr_m) | set_m;
        @(posedge clk); #1;
        check(tag, "irq_norm", {31'h0, irq_norm}, {31'h0, en});
        check(tag, "irq_err",  {31'h0, irq_err},  {31'h0, ee});
    endtask

    task automatic hset(input logic [31:0] d, input string tag);
        step(1, 1, HOFS, d, 0, 0, 0, 0, norm_mask, err_mask, tag);
    endtask
    task automatic cclr(input logic [31:0] d, input string tag);
        step(0, 0, 0, 0, 1, 1, COFS, d, norm_mask, err_mask, tag);
    endtask
    task automatic rdboth(input string tag);
        step(1, 0, HOFS, 0, 1, 0, COFS, 0, norm_mask, err_mask, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "irq_norm in reset", {31'h0, irq_norm}, 0);
        check("R1", "irq_err in reset",  {31'h0, irq_err}, 0);
        rst_n = 1'b1;
        rdboth("R1");
        hset(32'h0000_0005, "R2");
        hset(32'h0000_0100, "R2");
        hset(32'h0000_0000, "R2");
        rdboth("R2");
        cclr(32'h0000_0001, "R3");
        cclr(32'h0000_0000, "R3");
        rdboth("R3");
        step(1, 1, HOFS, 32'h10, 1, 1, COFS, 32'h14, 0, 0, "R4");
        rdboth("R4");
        step(1, 1, COFS, 32'hFFFF, 1, 1, HOFS, 32'hFFFF_FFFF, 0, 0, "R5");
        step(1, 1, 16'h0024, 32'hF0, 1, 1, 16'h4024, 32'hFFFF_FFFF, 0, 0, "R5");
        rdboth("R5");
        step(1, 0, COFS, 0, 1, 0, HOFS, 0, 0, 0, "R6");
        rdboth("R6");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
        step(1, 1, HOFS, 32'h8000_0000, 0, 0, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
        cclr(32'h7FFF_FFFF, "R8");
        rdboth("R8");
        cclr(32'hFFFF_FFFF, "R3");
        rdboth("R3");
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a1, a2;
            logic [31:0] d1, d2;
            a1 = ($urandom % 4 != 0) ? HOFS : (($urandom % 2) ? COFS : 16'($urandom));
            a2 = ($urandom % 4 != 0) ? COFS : (($urandom % 2) ? HOFS : 16'($urandom));
            d1 = $urandom & $urandom & $urandom;
            d2 = $urandom | $urandom;
            step($urandom % 2, $urandom % 2, a1, d1, $urandom % 2, $urandom % 3 == 0, a2, d2,
                 $urandom % 4 == 0, $urandom % 4 == 0, "R6");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule